// File: doc/BRIEF.md
# BCD Calendar Alarm Comparator

This block sits next to a BCD real-time clock and watches its live time and date for one programmed moment. It keeps one alarm register with second, minute, hour and day-of-month fields in BCD. Each field has its own ignore bit, so the alarm can fire every minute, every hour, every day, or once a month. The clock core presents its live time in the same packed layout and gives one strobe per second. The block compares the alarm against the live time only on that strobe. A match sets a sticky flag that software clears. The flag, gated by an interrupt enable, drives a level interrupt and a one-cycle event pulse for an edge-sensitive external event line.

The alarm register may be reloaded only while the alarm is switched off. Turning the alarm off raises a write-allowed status one clock later. A write is taken only when that status is high and the clock core reports its write protection as unlocked. Writes at any other time leave the register as it was.

Top module: `cal_alarm_top`

## Requirements
- R1: After reset, the alarm and interrupt enables are 0, the alarm register reads 0, the flag, interrupt and event outputs are 0, and write-allowed is 1.
- R2: The alarm register layout is: seconds BCD in bits [6:0] with its ignore bit at 7; minutes in [14:8] with ignore at 15; hours in [21:16], a PM bit at 22 and the hour ignore at 23; day in [29:24] with ignore at 31. Bit 30 is reserved and always reads 0. `live_time` uses the same field positions, and its bits 7, 15, 23, 30 and 31 are not used.
- R3: A register write (`alm_we`) takes effect at the next clock edge only when `wr_allowed` is 1 and `wr_unlocked` is 1. Otherwise the register does not change.
- R4: `wr_allowed` is 0 in every cycle in which the alarm is enabled. It falls at the same edge that enables the alarm. After a control write clears the enable, it stays 0 for one more clock and is 1 from the following edge.
- R5: Comparison happens only in a cycle where `tick_1hz` is 1 and the alarm is enabled. If every field that is not ignored equals the live value, the flag is 1 after that clock edge. The hour field includes the PM bit.
- R6: A field whose ignore bit is set counts as matching, whatever its live value.
- R7: The flag stays set until a cycle with `flag_clr` set and no new match. If a match and a clear occur in the same cycle, the flag stays set.
- R8: `alm_irq` is 1 exactly while the flag and the interrupt enable are both 1.
- R9: `alm_evt` is a single-cycle pulse for each rising edge of `alm_irq`. With the default `EVT_REG=0` it occurs in the first cycle in which `alm_irq` is high.
- R10: No flag is set when any field that is not ignored differs from the live value, when the alarm is disabled, or when there is no tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-cycle strobe for each one-second update of the live time |
| live_time | input | 32 | Live time and day from the clock core, in the alarm register layout |
| wr_unlocked | input | 1 | Write protection of the clock core is unlocked |
| ctl_we | input | 1 | Write strobe for the enable controls |
| ctl_en | input | 1 | New alarm enable value |
| ctl_ie | input | 1 | New interrupt enable value |
| alm_we | input | 1 | Write strobe for the alarm register |
| alm_wdata | input | 32 | Alarm register write data |
| flag_clr | input | 1 | Clear the sticky match flag |
| alm_rdata | output | 32 | Alarm register contents |
| alm_en | output | 1 | Alarm enable state |
| alm_ie | output | 1 | Interrupt enable state |
| wr_allowed | output | 1 | Alarm register may be written |
| alm_flag | output | 1 | Sticky match flag |
| alm_irq | output | 1 | Level interrupt |
| alm_evt | output | 1 | One-cycle pulse on each interrupt rising edge |

## Verification
On every cycle, the embedded properties check the following. Write-allowed is low whenever the alarm is on, and it rises only after the enable is off. A rejected write leaves the register unchanged. The flag rises only on an enabled tick that matched, and it holds until cleared. The event output never lasts two cycles. The bench scenarios are needed for the rest: the exact field and ignore-bit positions, the PM bit taking part in the hour comparison, the order of precedence when a set and a clear happen together, and the fact that only a tick starts a comparison.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

   localparam int REG_W      = 32;
   localparam int NUM_FIELDS = 4;
   localparam int FIELD_STEP = 8;
   localparam int MASK_OFS   = 7;

   typedef enum int {
      FLD_SEC  = 0,
      FLD_MIN  = 1,
      FLD_HOUR = 2,
      FLD_DAY  = 3
   } field_e;

   // least significant bit of each field
   function automatic int fld_lsb(input int idx);
      return idx * FIELD_STEP;
   endfunction

   // compared width; the hour field carries its PM bit as its top bit
   function automatic int fld_w(input int idx);
      return (idx == FLD_DAY) ? 6 : 7;
   endfunction

   // bits that hold state: every field bit and every ignore bit
   function automatic logic [REG_W-1:0] writable_bits();
      logic [REG_W-1:0] m;
      m = '0;
      for (int i = 0; i < NUM_FIELDS; i++) begin
         for (int b = 0; b < fld_w(i); b++) m[fld_lsb(i) + b] = 1'b1;
         m[fld_lsb(i) + MASK_OFS] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp #(
   parameter int W = 7
) (
   input  logic [W-1:0] alm_val,
   input  logic [W-1:0] live_val,
   input  logic         ignore,
   output logic         hit
);

   initial begin
      assert (W > 0 && W <= 8) else $error("alarm_field_cmp: bad W");
   end

   always_comb hit = ignore || (alm_val == live_val);

endmodule

// File: rtl/alarm_match.sv
module alarm_match
   import cal_alarm_pkg::*;
(
   input  logic [REG_W-1:0] alm_q,
   input  logic [REG_W-1:0] live,
   output logic             all_hit
);

   logic [NUM_FIELDS-1:0] hits;

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
      localparam int LSB = fld_lsb(g);
      localparam int FW  = fld_w(g);
      alarm_field_cmp #(.W(FW)) u_cmp (
         .alm_val (alm_q[LSB +: FW]),
         .live_val(live[LSB +: FW]),
         .ignore  (alm_q[LSB + MASK_OFS]),
         .hit     (hits[g])
      );
   end

   always_comb all_hit = &hits;

   // live ignore/reserved positions and alarm bit 30 are not compared
   logic unused_live;
   always_comb unused_live = ^{live[7], live[15], live[23], live[31:30], alm_q[30]};

endmodule

// File: rtl/alarm_cfg_regs.sv
module alarm_cfg_regs
   import cal_alarm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic             ctl_en,
   input  logic             ctl_ie,
   input  logic             alm_we,
   input  logic [REG_W-1:0] alm_wdata,
   input  logic             unlocked,
   output logic             en_q,
   output logic             ie_q,
   output logic             wra_q,
   output logic [REG_W-1:0] alm_q
);

   localparam logic [REG_W-1:0] WMASK = writable_bits();

   logic en_d;
   logic wr_ok;

   always_comb begin
      en_d  = ctl_we ? ctl_en : en_q;
      wr_ok = alm_we && wra_q && unlocked;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         ie_q  <= 1'b0;
         wra_q <= 1'b1;
         alm_q <= '0;
      end else begin
         en_q  <= en_d;
         if (ctl_we) ie_q <= ctl_ie;
         // drops with the enable, rises one clock after it is cleared
         wra_q <= !en_d && !en_q;
         if (wr_ok) alm_q <= alm_wdata & WMASK;
      end
   end

   // R4: no write window while the alarm is on
   p_wra_low_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en_q |-> !wra_q);

   // R4: write window opens only after a full cycle of disabled state
   p_wra_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wra_q) |-> (!en_q && $past(!en_q)));

   // R3: rejected writes leave the register alone
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (alm_we && !(wra_q && unlocked)) |=> $stable(alm_q));

endmodule

// File: rtl/alarm_flag_irq.sv
module alarm_flag_irq #(
   parameter int EVT_REG = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic en,
   input  logic hit,
   input  logic clr,
   input  logic ie,
   output logic flag_q,
   output logic irq,
   output logic evt
);

   initial begin
      assert (EVT_REG == 0 || EVT_REG == 1) else $error("alarm_flag_irq: bad EVT_REG");
   end

   logic set_now;
   logic irq_q;

   always_comb begin
      set_now = tick && en && hit;
      irq     = flag_q && ie;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (set_now)  flag_q <= 1'b1;
         else if (clr) flag_q <= 1'b0;
         irq_q <= irq;
      end
   end

   if (EVT_REG == 0) begin : g_evt_comb
      always_comb evt = irq && !irq_q;
   end else begin : g_evt_reg
      logic evt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) evt_q <= 1'b0;
         else        evt_q <= irq && !irq_q;
      end
      always_comb evt = evt_q;
   end

   // R5: flag rises only after an enabled, matching tick
   p_flag_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(tick && en && hit));

   // R7: flag is sticky without a clear
   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q);

   // R9: event lasts one cycle
   p_evt_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);

endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
   import cal_alarm_pkg::*;
#(
   parameter int EVT_REG = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        tick_1hz,
   input  logic [31:0] live_time,
   input  logic        wr_unlocked,
   input  logic        ctl_we,
   input  logic        ctl_en,
   input  logic        ctl_ie,
   input  logic        alm_we,
   input  logic [31:0] alm_wdata,
   input  logic        flag_clr,
   output logic [31:0] alm_rdata,
   output logic        alm_en,
   output logic        alm_ie,
   output logic        wr_allowed,
   output logic        alm_flag,
   output logic        alm_irq,
   output logic        alm_evt
);

   initial begin
      assert (REG_W == 32) else $error("cal_alarm_top: register width must be 32");
   end

   logic [REG_W-1:0] alm_q;
   logic             all_hit;

   alarm_cfg_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctl_we   (ctl_we),
      .ctl_en   (ctl_en),
      .ctl_ie   (ctl_ie),
      .alm_we   (alm_we),
      .alm_wdata(alm_wdata),
      .unlocked (wr_unlocked),
      .en_q     (alm_en),
      .ie_q     (alm_ie),
      .wra_q    (wr_allowed),
      .alm_q    (alm_q)
   );

   alarm_match u_match (
      .alm_q  (alm_q),
      .live   (live_time),
      .all_hit(all_hit)
   );

   alarm_flag_irq #(.EVT_REG(EVT_REG)) u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_1hz),
      .en    (alm_en),
      .hit   (all_hit),
      .clr   (flag_clr),
      .ie    (alm_ie),
      .flag_q(alm_flag),
      .irq   (alm_irq),
      .evt   (alm_evt)
   );

   always_comb alm_rdata = alm_q;

endmodule

// File: tb/cal_alarm_top_tb_top.sv
module cal_alarm_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_1hz = 1'b0;
   logic [31:0] live_time = '0;
   logic        wr_unlocked = 1'b0;
   logic        ctl_we = 1'b0, ctl_en = 1'b0, ctl_ie = 1'b0;
   logic        alm_we = 1'b0;
   logic [31:0] alm_wdata = '0;
   logic        flag_clr = 1'b0;
   logic [31:0] alm_rdata;
   logic        alm_en, alm_ie, wr_allowed, alm_flag, alm_irq, alm_evt;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   cal_alarm_top dut_i (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .live_time(live_time),
      .wr_unlocked(wr_unlocked), .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_ie(ctl_ie),
      .alm_we(alm_we), .alm_wdata(alm_wdata), .flag_clr(flag_clr),
      .alm_rdata(alm_rdata), .alm_en(alm_en), .alm_ie(alm_ie),
      .wr_allowed(wr_allowed), .alm_flag(alm_flag), .alm_irq(alm_irq), .alm_evt(alm_evt)
   );

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic write_ctl(input logic en, input logic ie);
      ctl_we = 1'b1; ctl_en = en; ctl_ie = ie;
      step();
      ctl_we = 1'b0;
   endtask

   task automatic write_alarm(input logic [31:0] v);
      alm_we = 1'b1; alm_wdata = v;
      step();
      alm_we = 1'b0;
   endtask

   task automatic pulse_tick();
      tick_1hz = 1'b1;
      step();
      tick_1hz = 1'b0;
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1;
      step();
      flag_clr = 1'b0;
   endtask

   // disable, wait for the write window, load, re-enable
   task automatic reprogram(input logic [31:0] v, input logic ie);
      write_ctl(1'b0, ie);
      step();
      write_alarm(v);
      write_ctl(1'b1, ie);
   endtask

   task automatic t_reset();
      chk("R1 enable", {31'd0, alm_en}, 32'd0);
      chk("R1 irq enable", {31'd0, alm_ie}, 32'd0);
      chk("R1 register", alm_rdata, 32'd0);
      chk("R1 flag/irq/evt", {29'd0, alm_flag, alm_irq, alm_evt}, 32'd0);
      chk("R1 write allowed", {31'd0, wr_allowed}, 32'd1);
   endtask

   task automatic t_layout();
      wr_unlocked = 1'b1;
      write_alarm(32'hFFFF_FFFF);
      chk("R2 reserved bit 30 reads 0", alm_rdata, 32'hBFFF_FFFF);
      write_alarm(32'h1523_5930);
      chk("R2 field load", alm_rdata, 32'h1523_5930);
   endtask

   task automatic t_guard();
      wr_unlocked = 1'b0;
      write_alarm(32'h0101_0101);
      chk("R3 locked write ignored", alm_rdata, 32'h1523_5930);
      wr_unlocked = 1'b1;
      write_ctl(1'b1, 1'b0);
      chk("R4 write allowed drops on enable", {31'd0, wr_allowed}, 32'd0);
      write_alarm(32'h0202_0202);
      chk("R3 write while enabled ignored", alm_rdata, 32'h1523_5930);
      write_ctl(1'b0, 1'b0);
      chk("R4 still closed one clock after disable", {31'd0, wr_allowed}, 32'd0);
      step();
      chk("R4 open two clocks after disable", {31'd0, wr_allowed}, 32'd1);
   endtask

   task automatic t_match();
      write_ctl(1'b1, 1'b1);
      live_time = 32'h1523_5930;
      step();
      chk("R5 no tick no flag", {31'd0, alm_flag}, 32'd0);
      pulse_tick();
      chk("R5 flag on matching tick", {31'd0, alm_flag}, 32'd1);
      chk("R8 irq with flag and ie", {31'd0, alm_irq}, 32'd1);
      chk("R9 event pulse first cycle", {31'd0, alm_evt}, 32'd1);
      step();
      chk("R9 event gone next cycle", {31'd0, alm_evt}, 32'd0);
      chk("R7 flag sticky", {31'd0, alm_flag}, 32'd1);
      write_ctl(1'b1, 1'b0);
      chk("R8 irq off without ie", {31'd0, alm_irq}, 32'd0);
      write_ctl(1'b1, 1'b1);
      chk("R9 event on new irq edge", {31'd0, alm_evt}, 32'd1);
      clear_flag();
      chk("R7 clear drops flag", {31'd0, alm_flag}, 32'd0);
      flag_clr = 1'b1;
      pulse_tick();
      flag_clr = 1'b0;
      chk("R7 set wins over clear", {31'd0, alm_flag}, 32'd1);
      clear_flag();
   endtask

   task automatic t_nomatch();
      live_time = 32'h1523_5931;
      pulse_tick();
      chk("R10 seconds differ", {31'd0, alm_flag}, 32'd0);
      live_time = 32'h1563_5930;
      pulse_tick();
      chk("R10 PM bit differs", {31'd0, alm_flag}, 32'd0);
      live_time = 32'h1423_5930;
      pulse_tick();
      chk("R10 day differs", {31'd0, alm_flag}, 32'd0);
      live_time = 32'h1523_5930;
      write_ctl(1'b0, 1'b1);
      pulse_tick();
      chk("R10 disabled no flag", {31'd0, alm_flag}, 32'd0);
   endtask

   task automatic t_mask();
      reprogram(32'h1523_59B0, 1'b1);
      chk("R6 register with seconds ignore", alm_rdata, 32'h1523_59B0);
      live_time = 32'h1523_5907;
      pulse_tick();
      chk("R6 ignored seconds match", {31'd0, alm_flag}, 32'd1);
      clear_flag();
      live_time = 32'h1523_5807;
      pulse_tick();
      chk("R10 minutes still compared", {31'd0, alm_flag}, 32'd0);
      reprogram(32'h8080_8080, 1'b1);
      live_time = 32'h0142_0304;
      pulse_tick();
      chk("R6 all fields ignored match", {31'd0, alm_flag}, 32'd1);
      clear_flag();
   endtask

   initial begin : wdog
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_layout();
      t_guard();
      t_match();
      t_nomatch();
      t_mask();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule